// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block sits beside the command decoder of a byte-wide flash array. It builds the status byte that the part returns on reads while a byte program or an erase runs, while an erase waits to suspend, and while an erase stays suspended. For every read it also decides whether the read must return that status byte or plain array contents. The command decoder reports each accepted operation with a one-cycle start pulse, the kind of operation, the target sector and bit 7 of the byte being programmed. The operation timer reports normal completion and a pulse-count overrun. Separate pulses request suspend, resume and error clear.

Reads arrive as a valid/ready request that carries the sector index of the read address. This is the upper address bits, from which the caller strips the in-sector offset. Each accepted request produces one registered response: a byte and a flag that says whether the byte is status. When the flag is low the caller returns array data instead. The response holds while `rsp_ready` is low, and `rd_ready` is high only when the response slot is empty or is being drained in the same cycle. Both toggle bits advance only on accepted reads, so a stalled read never consumes a toggle.

Operations aimed at protected sectors are not rejected silently. The status output keeps toggling for a guard window whose length is set in clock cycles, and the block then returns to its previous mode.

Top module: `flash_op_status`

## Requirements
- R1: With no operation running, and again after `op_done` ends a program or an erase, every accepted read returns `rsp_status`=0 and `rsp_data`=00h.
- R2: Status bit 7 reads as the inverse of `op_data7` during a program, during a program inside an erase suspend, during the guard window of a protected program, and after a program timeout. It reads 0 during an active or suspend-pending erase and during its failure state. It reads 1 on reads inside a suspended sector.
- R3: Status bit 6 shows the current value of a toggle flop and then inverts it on every accepted read while a program, an erase, a suspend-pending erase, a guard window or a failure is in progress. During a completed suspend it holds.
- R4: Status bit 5 sets when `op_timeout` arrives during an active program or erase. Every read then returns status with bit 5 = 1 until `clr_err`, after which reads return array data. `op_timeout` has no effect while the block is idle or suspended.
- R5: Status bit 3 is 1 from the cycle after a sector-erase start until the block returns to idle, including the suspend and any program inside it. It is 0 for a program and for a chip erase.
- R6: Status bit 2 comes from a second toggle flop. It inverts only on accepted reads whose sector is selected for erase, while the erase is active, pending suspend, suspended or failed. A chip erase selects every sector. Reads outside the selection report its value without changing it.
- R7: `susp_req` during an active sector erase keeps the erase status active for exactly `SUSP_LAT_CYC` cycles. After that, reads in the erased sector return status with bit 7 = 1 and bit 6 steady, and reads in other sectors return array data. `susp_req` during a chip erase or a program has no effect.
- R8: `resume_req` in suspend returns to active erase. A program start during suspend returns status at every sector, and its `op_done` returns to suspend.
- R9: A program whose target sector has its `prot_mask` bit set shows a toggling status for exactly `PGM_GUARD_CYC` cycles. An erase whose selected sectors are all protected does the same for `ERS_GUARD_CYC` cycles. In both cases the block then returns to its previous mode.
- R10: `op_start` is ignored while any operation, guard window or failure is in progress. The one exception is a program start during suspend.
- R11: `rd_ready` equals the inverse of `rsp_valid` ORed with `rsp_ready`. A response stays valid and unchanged while `rsp_ready` is low, and each accepted read yields a response in the next cycle.
- R12: In a status byte, bits 4, 1 and 0 are 0.
- R13: A read accepted in the same cycle as a control pulse sees the mode from before that pulse. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse: the decoder accepted an operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 no operation |
| op_sect | input | SECT_W | Sector index of the program or erase target |
| op_data7 | input | 1 | Bit 7 of the byte being programmed |
| prot_mask | input | 2**SECT_W | One bit per sector, 1 = protected |
| op_done | input | 1 | Timer pulse: the operation completed normally |
| op_timeout | input | 1 | Timer pulse: pulse-count limit exceeded |
| susp_req | input | 1 | Erase suspend command pulse |
| resume_req | input | 1 | Erase resume command pulse |
| clr_err | input | 1 | Reset command pulse, leaves the failure state |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle when high with rd_valid |
| rd_sect | input | SECT_W | Sector index of the read address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Status byte, 00h when rsp_status is low |
| rsp_status | output | 1 | 1 = return rsp_data, 0 = return array contents |

## Verification
The bench tries reads that are stalled by `rsp_ready`. A design that advanced a toggle on an offered read rather than on an accepted one would show bit 6 skipping a value. It also issues reads in the same cycle as a start pulse, where a design that let the new mode leak into that read would return status one read early. The suspend latency and both guard windows are counted to the exact cycle, so an off-by-one counter would turn a status read into an array read at the window edge. Reads inside and outside the erased sector during suspend, program-in-suspend, chip erase and failure show whether bit 2 is gated by sector and by mode, and whether bit 7 takes the suspend value rather than the erase value.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;

  typedef enum logic [1:0] {
    OPK_PROG   = 2'd0,
    OPK_SERASE = 2'd1,
    OPK_CERASE = 2'd2,
    OPK_NONE   = 2'd3
  } opk_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PROG  = 3'd1,
    PH_ERASE = 3'd2,
    PH_SPEND = 3'd3,
    PH_SUSP  = 3'd4,
    PH_SPROG = 3'd5,
    PH_GUARD = 3'd6,
    PH_FAIL  = 3'd7
  } phase_e;

  typedef struct packed {
    logic poll;
    logic tog;
    logic tmo;
    logic started;
    logic stog;
  } sts_fields_t;

  // bit positions the host software decodes
  localparam int unsigned B_POLL    = 7;
  localparam int unsigned B_TOG     = 6;
  localparam int unsigned B_TMO     = 5;
  localparam int unsigned B_STARTED = 3;
  localparam int unsigned B_STOG    = 2;

  function automatic logic [7:0] pack_status(input sts_fields_t f);
    logic [7:0] b;
    b            = '0;
    b[B_POLL]    = f.poll;
    b[B_TOG]     = f.tog;
    b[B_TMO]     = f.tmo;
    b[B_STARTED] = f.started;
    b[B_STOG]    = f.stog;
    return b;
  endfunction

endpackage

// File: rtl/flash_sts_phase.sv
module flash_sts_phase
  import flash_sts_pkg::*;
#(
  parameter int PGM_GUARD = 200,
  parameter int ERS_GUARD = 10000,
  parameter int SUSP_LAT  = 2000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   op_start,
  input  opk_e   op_kind,
  input  logic   op_data7,
  input  logic   tgt_prot,
  input  logic   ers_all_prot,
  input  logic   op_done,
  input  logic   op_timeout,
  input  logic   susp_req,
  input  logic   resume_req,
  input  logic   clr_err,
  output phase_e phase,
  output logic   op_is_prog,
  output logic   sect_ers,
  output logic   err,
  output logic   pgm_d7,
  output logic   sel_load
);

  localparam int LIM_A   = (PGM_GUARD > ERS_GUARD) ? PGM_GUARD : ERS_GUARD;
  localparam int LIM_MAX = (LIM_A > SUSP_LAT) ? LIM_A : SUSP_LAT;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] PGM_LD = CNT_W'(PGM_GUARD - 1);
  localparam logic [CNT_W-1:0] ERS_LD = CNT_W'(ERS_GUARD - 1);
  localparam logic [CNT_W-1:0] SUS_LD = CNT_W'(SUSP_LAT - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  phase_e           phase_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             isprog_n, sect_n, err_n, d7_n, ret, ret_n;

  always_comb begin
    phase_n  = phase;
    cnt_n    = cnt;
    isprog_n = op_is_prog;
    sect_n   = sect_ers;
    err_n    = err;
    d7_n     = pgm_d7;
    ret_n    = ret;
    sel_load = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (op_start) begin
          if (op_kind == OPK_PROG) begin
            isprog_n = 1'b1;
            d7_n     = op_data7;
            ret_n    = 1'b0;
            if (tgt_prot) begin
              phase_n = PH_GUARD;
              cnt_n   = PGM_LD;
            end else begin
              phase_n = PH_PROG;
            end
          end else if (op_kind == OPK_SERASE || op_kind == OPK_CERASE) begin
            isprog_n = 1'b0;
            ret_n    = 1'b0;
            sect_n   = (op_kind == OPK_SERASE);
            if (ers_all_prot) begin
              phase_n = PH_GUARD;
              cnt_n   = ERS_LD;
            end else begin
              phase_n  = PH_ERASE;
              sel_load = 1'b1;
            end
          end
        end
      end
      PH_PROG: begin
        if (op_timeout) begin
          phase_n = PH_FAIL;
          err_n   = 1'b1;
        end else if (op_done) begin
          phase_n = PH_IDLE;
        end
      end
      PH_ERASE: begin
        if (op_timeout) begin
          phase_n = PH_FAIL;
          err_n   = 1'b1;
        end else if (op_done) begin
          phase_n = PH_IDLE;
        end else if (susp_req && sect_ers) begin
          phase_n = PH_SPEND;
          cnt_n   = SUS_LD;
        end
      end
      PH_SPEND: begin
        if (op_timeout) begin
          phase_n = PH_FAIL;
          err_n   = 1'b1;
        end else if (op_done) begin
          phase_n = PH_IDLE;
        end else if (cnt == '0) begin
          phase_n = PH_SUSP;
        end else begin
          cnt_n = cnt - ONE;
        end
      end
      PH_SUSP: begin
        if (resume_req) begin
          phase_n = PH_ERASE;
        end else if (op_start && op_kind == OPK_PROG) begin
          isprog_n = 1'b1;
          d7_n     = op_data7;
          if (tgt_prot) begin
            phase_n = PH_GUARD;
            cnt_n   = PGM_LD;
            ret_n   = 1'b1;
          end else begin
            phase_n = PH_SPROG;
          end
        end
      end
      PH_SPROG: begin
        if (op_timeout) begin
          phase_n = PH_FAIL;
          err_n   = 1'b1;
        end else if (op_done) begin
          phase_n  = PH_SUSP;
          isprog_n = 1'b0;
        end
      end
      PH_GUARD: begin
        if (cnt == '0) begin
          phase_n  = ret ? PH_SUSP : PH_IDLE;
          isprog_n = 1'b0;
        end else begin
          cnt_n = cnt - ONE;
        end
      end
      PH_FAIL: begin
        if (clr_err) begin
          phase_n = PH_IDLE;
          err_n   = 1'b0;
        end
      end
    endcase
    if (phase_n == PH_IDLE) sect_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      op_is_prog <= 1'b0;
      sect_ers   <= 1'b0;
      err        <= 1'b0;
      pgm_d7     <= 1'b0;
      ret        <= 1'b0;
    end else begin
      phase      <= phase_n;
      cnt        <= cnt_n;
      op_is_prog <= isprog_n;
      sect_ers   <= sect_n;
      err        <= err_n;
      pgm_d7     <= d7_n;
      ret        <= ret_n;
    end
  end

endmodule

// File: rtl/flash_sts_sector.sv
module flash_sts_sector #(
  parameter int SECT_W = 5,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SECT_W-1:0] op_sect,
  input  logic              chip_wide,
  input  logic              sel_load,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic [SECT_W-1:0] rd_sect,
  output logic              tgt_prot,
  output logic              ers_all_prot,
  output logic              rd_in_sel
);

  logic [NSECT-1:0] hit;
  logic [NSECT-1:0] sel_mask;

  for (genvar i = 0; i < NSECT; i++) begin : g_dec
    assign hit[i] = (op_sect == SECT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_mask <= '0;
    end else if (sel_load) begin
      sel_mask <= chip_wide ? {NSECT{1'b1}} : hit;
    end
  end

  assign tgt_prot     = |(prot_mask & hit);
  assign ers_all_prot = chip_wide ? (&prot_mask) : tgt_prot;
  assign rd_in_sel    = sel_mask[rd_sect];

endmodule

// File: rtl/flash_sts_toggle.sv
module flash_sts_toggle #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] adv,
  output logic [NT-1:0] q
);

  for (genvar i = 0; i < NT; i++) begin : g_tff
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (adv[i]) q[i] <= ~q[i];
    end
  end

endmodule

// File: rtl/flash_sts_resp.sv
module flash_sts_resp
  import flash_sts_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_valid,
  input  logic        rsp_ready,
  input  logic        is_status,
  input  sts_fields_t fields,
  output logic        rd_ready,
  output logic        accept,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_status
);

  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_status <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_status <= is_status;
      rsp_data   <= is_status ? pack_status(fields) : 8'h00;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_sts_pkg::*;
#(
  parameter int SECT_W        = 5,
  parameter int PGM_GUARD_CYC = 200,
  parameter int ERS_GUARD_CYC = 10000,
  parameter int SUSP_LAT_CYC  = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_start,
  input  logic [1:0]               op_kind,
  input  logic [SECT_W-1:0]        op_sect,
  input  logic                     op_data7,
  input  logic [(1<<SECT_W)-1:0]   prot_mask,
  input  logic                     op_done,
  input  logic                     op_timeout,
  input  logic                     susp_req,
  input  logic                     resume_req,
  input  logic                     clr_err,
  input  logic                     rd_valid,
  output logic                     rd_ready,
  input  logic [SECT_W-1:0]        rd_sect,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [7:0]               rsp_data,
  output logic                     rsp_status
);

  localparam int T_MAIN = 0;
  localparam int T_SECT = 1;

  opk_e        kind;
  phase_e      phase;
  logic        op_is_prog, sect_ers, err, pgm_d7, sel_load;
  logic        tgt_prot, ers_all_prot, rd_in_sel;
  logic        accept, is_status;
  logic [1:0]  adv, tq;
  sts_fields_t fields;

  assign kind = opk_e'(op_kind);

  flash_sts_phase #(
    .PGM_GUARD (PGM_GUARD_CYC),
    .ERS_GUARD (ERS_GUARD_CYC),
    .SUSP_LAT  (SUSP_LAT_CYC)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_start     (op_start),
    .op_kind      (kind),
    .op_data7     (op_data7),
    .tgt_prot     (tgt_prot),
    .ers_all_prot (ers_all_prot),
    .op_done      (op_done),
    .op_timeout   (op_timeout),
    .susp_req     (susp_req),
    .resume_req   (resume_req),
    .clr_err      (clr_err),
    .phase        (phase),
    .op_is_prog   (op_is_prog),
    .sect_ers     (sect_ers),
    .err          (err),
    .pgm_d7       (pgm_d7),
    .sel_load     (sel_load)
  );

  flash_sts_sector #(.SECT_W(SECT_W)) u_sector (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_sect      (op_sect),
    .chip_wide    (kind == OPK_CERASE),
    .sel_load     (sel_load),
    .prot_mask    (prot_mask),
    .rd_sect      (rd_sect),
    .tgt_prot     (tgt_prot),
    .ers_all_prot (ers_all_prot),
    .rd_in_sel    (rd_in_sel)
  );

  // which reads are answered with status
  always_comb begin
    unique case (phase)
      PH_IDLE: is_status = 1'b0;
      PH_SUSP: is_status = rd_in_sel;
      default: is_status = 1'b1;
    endcase
  end

  // polling bit per mode
  always_comb begin
    unique case (phase)
      PH_PROG, PH_SPROG:   fields.poll = ~pgm_d7;
      PH_SUSP:             fields.poll = 1'b1;
      PH_GUARD, PH_FAIL:   fields.poll = op_is_prog ? ~pgm_d7 : 1'b0;
      default:             fields.poll = 1'b0;
    endcase
  end

  logic main_live, sect_live;
  assign main_live = (phase != PH_IDLE) && (phase != PH_SUSP);
  assign sect_live = (phase == PH_ERASE) || (phase == PH_SPEND) || (phase == PH_SUSP) ||
                     ((phase == PH_FAIL) && !op_is_prog);

  assign adv[T_MAIN] = accept && main_live;
  assign adv[T_SECT] = accept && sect_live && rd_in_sel;

  flash_sts_toggle #(.NT(2)) u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .q     (tq)
  );

  assign fields.tog     = tq[T_MAIN];
  assign fields.stog    = tq[T_SECT];
  assign fields.tmo     = err;
  assign fields.started = sect_ers;

  flash_sts_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rsp_ready  (rsp_ready),
    .is_status  (is_status),
    .fields     (fields),
    .rd_ready   (rd_ready),
    .accept     (accept),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_status (rsp_status)
  );

endmodule

// File: rtl/flash_sts_chk.sv
module flash_sts_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_status
);

  // R11: a stalled response is held unchanged
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));

  // R11: an accepted read is answered in the next cycle
  a_r11_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rsp_valid);

  // R11: a response never appears without an offered read
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> (!rsp_valid || $past(rd_valid)));

  // R12: reserved status positions stay clear
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status |-> (rsp_data[4] == 1'b0) && (rsp_data[1:0] == 2'b00));

  // R1: array-data answers carry a zero byte
  a_r1_array_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_status |-> rsp_data == 8'h00);

endmodule

bind flash_op_status flash_sts_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_status (rsp_status)
);

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;

  localparam int SW   = 5;
  localparam int PGC  = 200;
  localparam int ERC  = 10000;
  localparam int SLC  = 2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 0, op_data7 = 0, op_done = 0, op_timeout = 0;
  logic          susp_req = 0, resume_req = 0, clr_err = 0;
  logic [1:0]    op_kind = 2'd3;
  logic [SW-1:0] op_sect = '0, rd_sect = '0;
  logic [31:0]   prot_mask = 32'h0000_0220; // sectors 5 and 9 protected
  logic          rd_valid = 0, rsp_ready = 1;
  logic          rd_ready, rsp_valid, rsp_status;
  logic [7:0]    rsp_data;

  always #5 clk = ~clk;

  flash_op_status #(.SECT_W(SW), .PGM_GUARD_CYC(PGC), .ERS_GUARD_CYC(ERC),
                    .SUSP_LAT_CYC(SLC)) dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_sect(op_sect), .op_data7(op_data7), .prot_mask(prot_mask),
    .op_done(op_done), .op_timeout(op_timeout), .susp_req(susp_req),
    .resume_req(resume_req), .clr_err(clr_err), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_sect(rd_sect), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_status(rsp_status));

  int    n_tests = 0, n_fail = 0;
  bit    done_flag = 0;
  string scen = "R1";

  // ---------------- reference model ----------------
  localparam int IDLE = 0, PROG = 1, ERS = 2, SPEND = 3, SUSP = 4, SPROG = 5,
                 GUARD = 6, FAIL = 7;
  int        m_mode = IDLE, m_cnt = 0;
  bit        m_ret, m_isprog, m_sect, m_err, m_d7, t6, t2;
  bit [31:0] m_sel;
  bit        e_valid, e_stat;
  bit [7:0]  e_data;

  always @(posedge clk) begin
    bit acc, insel, st, b7;
    int s;
    if (!rst_n) begin
      m_mode = IDLE; m_cnt = 0; m_ret = 0; m_isprog = 0; m_sect = 0; m_err = 0;
      m_d7 = 0; t6 = 0; t2 = 0; m_sel = '0; e_valid = 0; e_stat = 0; e_data = 0;
    end else begin
      acc = rd_valid && (!e_valid || rsp_ready);
      if (acc) begin
        s = int'(rd_sect);
        insel = m_sel[s];
        st = (m_mode != IDLE) && !(m_mode == SUSP && !insel);
        if (m_mode == PROG || m_mode == SPROG) b7 = !m_d7;
        else if (m_mode == SUSP) b7 = 1;
        else if (m_mode == GUARD || m_mode == FAIL) b7 = m_isprog ? !m_d7 : 1'b0;
        else b7 = 0;
        e_valid = 1;
        e_stat  = st;
        e_data  = st ? {b7, t6, m_err, 1'b0, m_sect, t2, 2'b00} : 8'h00;
        if (m_mode != IDLE && m_mode != SUSP) t6 = !t6;
        if (insel && (m_mode == ERS || m_mode == SPEND || m_mode == SUSP ||
                      (m_mode == FAIL && !m_isprog))) t2 = !t2;
      end else if (rsp_ready) e_valid = 0;

      case (m_mode)
        IDLE: if (op_start) begin
          if (op_kind == 2'd0) begin
            m_isprog = 1; m_d7 = op_data7; m_ret = 0;
            if (prot_mask[op_sect]) begin m_mode = GUARD; m_cnt = PGC - 1; end
            else m_mode = PROG;
          end else if (op_kind == 2'd1 || op_kind == 2'd2) begin
            m_isprog = 0; m_ret = 0; m_sect = (op_kind == 2'd1);
            if ((op_kind == 2'd2) ? (&prot_mask) : prot_mask[op_sect]) begin
              m_mode = GUARD; m_cnt = ERC - 1;
            end else begin
              m_mode = ERS;
              m_sel = (op_kind == 2'd2) ? 32'hFFFF_FFFF : (32'd1 << op_sect);
            end
          end
        end
        PROG:  if (op_timeout) begin m_mode = FAIL; m_err = 1; end
               else if (op_done) m_mode = IDLE;
        ERS:   if (op_timeout) begin m_mode = FAIL; m_err = 1; end
               else if (op_done) m_mode = IDLE;
               else if (susp_req && m_sect) begin m_mode = SPEND; m_cnt = SLC - 1; end
        SPEND: if (op_timeout) begin m_mode = FAIL; m_err = 1; end
               else if (op_done) m_mode = IDLE;
               else if (m_cnt == 0) m_mode = SUSP;
               else m_cnt--;
        SUSP:  if (resume_req) m_mode = ERS;
               else if (op_start && op_kind == 2'd0) begin
                 m_isprog = 1; m_d7 = op_data7;
                 if (prot_mask[op_sect]) begin m_mode = GUARD; m_cnt = PGC - 1; m_ret = 1; end
                 else m_mode = SPROG;
               end
        SPROG: if (op_timeout) begin m_mode = FAIL; m_err = 1; end
               else if (op_done) begin m_mode = SUSP; m_isprog = 0; end
        GUARD: if (m_cnt == 0) begin m_mode = m_ret ? SUSP : IDLE; m_isprog = 0; end
               else m_cnt--;
        FAIL:  if (clr_err) begin m_mode = IDLE; m_err = 0; end
        default: ;
      endcase
      if (m_mode == IDLE) m_sect = 0;
    end
  end

  // ---------------- comparison on every clock ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s: got %0h expected %0h", req, scen, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done_flag) begin
      check(rd_ready === (!e_valid || rsp_ready), "R11", "rd_ready", rd_ready, !e_valid || rsp_ready);
      check(rsp_valid === e_valid, "R11", "rsp_valid", rsp_valid, e_valid);
      if (e_valid) begin
        check(rsp_status === e_stat, (m_mode == SUSP) ? "R7" : "R1", "rsp_status", rsp_status, e_stat);
        check(rsp_data[7] === e_data[7], "R2", "bit7", rsp_data, e_data);
        check(rsp_data[6] === e_data[6], "R3", "bit6", rsp_data, e_data);
        check(rsp_data[5] === e_data[5], "R4", "bit5", rsp_data, e_data);
        check(rsp_data[3] === e_data[3], "R5", "bit3", rsp_data, e_data);
        check(rsp_data[2] === e_data[2], "R6", "bit2", rsp_data, e_data);
        check({rsp_data[4], rsp_data[1:0]} === 3'b000, "R12", "reserved", rsp_data, e_data);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic rd(input logic [SW-1:0] s);
    @(negedge clk);
    rd_valid = 1; rd_sect = s;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic start(input logic [1:0] k, input logic [SW-1:0] s, input bit d7);
    @(negedge clk);
    op_start = 1; op_kind = k; op_sect = s; op_data7 = d7;
    @(negedge clk);
    op_start = 0;
  endtask

  // 0 done, 1 timeout, 2 suspend, 3 resume, 4 clear
  task automatic pulse(input int w);
    @(negedge clk);
    case (w)
      0: op_done = 1;
      1: op_timeout = 1;
      2: susp_req = 1;
      3: resume_req = 1;
      default: clr_err = 1;
    endcase
    @(negedge clk);
    op_done = 0; op_timeout = 0; susp_req = 0; resume_req = 0; clr_err = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state and idle reads
    scen = "R1";
    rd(5'd1); rd(5'd31);

    // R2 R3: program, then completion returns array data
    scen = "R2";
    start(2'd0, 5'd2, 1'b1);
    rd(5'd2); rd(5'd7); rd(5'd2);
    pulse(0); rd(5'd2);
    start(2'd0, 5'd3, 1'b0);
    scen = "R3";
    rd(5'd0); rd(5'd3); rd(5'd30);
    pulse(0); rd(5'd3);

    // R4 R10: timeout, ignored start, clear
    scen = "R4";
    start(2'd0, 5'd4, 1'b1);
    rd(5'd4); pulse(1); rd(5'd4); rd(5'd12);
    scen = "R10";
    start(2'd1, 5'd6, 1'b0); rd(5'd6);
    scen = "R4";
    pulse(4); rd(5'd4); pulse(1); rd(5'd4);

    // R5 R6 R7 R8: sector erase, suspend, program in suspend, resume
    scen = "R5";
    start(2'd1, 5'd3, 1'b0);
    rd(5'd3); rd(5'd7);
    scen = "R6";
    rd(5'd3); rd(5'd3); rd(5'd8);
    scen = "R10";
    start(2'd0, 5'd7, 1'b0); rd(5'd7);
    scen = "R7";
    pulse(2); rd(5'd3); rd(5'd7);
    idle(SLC);
    rd(5'd3); rd(5'd3); rd(5'd7); rd(5'd3);
    scen = "R8";
    start(2'd0, 5'd7, 1'b0);
    rd(5'd7); rd(5'd3); rd(5'd20);
    pulse(0); rd(5'd7); rd(5'd3);
    scen = "R9";
    start(2'd0, 5'd5, 1'b1);
    rd(5'd5); idle(PGC / 2); rd(5'd3); idle(PGC); rd(5'd3); rd(5'd5);
    scen = "R8";
    pulse(3); rd(5'd3); rd(5'd9);
    pulse(0); rd(5'd3);

    // R7 R6: chip erase ignores suspend, all sectors selected, failure
    scen = "R7";
    start(2'd2, 5'd0, 1'b0);
    rd(5'd11); pulse(2); idle(SLC + 10); rd(5'd11); rd(5'd29);
    scen = "R6";
    pulse(1); rd(5'd11); rd(5'd1); pulse(4); rd(5'd11);

    // R9: protected program and protected erase windows
    scen = "R9";
    start(2'd0, 5'd9, 1'b0);
    rd(5'd9); idle(PGC - 8); rd(5'd9); rd(5'd9); rd(5'd9); rd(5'd9);
    start(2'd1, 5'd5, 1'b0);
    rd(5'd5); idle(ERC - 12); rd(5'd5); rd(5'd5); rd(5'd5); rd(5'd5); rd(5'd5);

    // R11: stalled responses do not consume toggles
    scen = "R11";
    start(2'd0, 5'd1, 1'b1);
    @(negedge clk); rsp_ready = 0;
    rd(5'd1);
    @(negedge clk); rd_valid = 1; rd_sect = 5'd2;
    idle(3);
    rsp_ready = 1;
    @(negedge clk); rd_valid = 0;
    rd(5'd1);
    pulse(0);

    // R13: read in the same cycle as a start sees the old mode
    scen = "R13";
    @(negedge clk);
    op_start = 1; op_kind = 2'd0; op_sect = 5'd2; op_data7 = 1'b0;
    rd_valid = 1; rd_sect = 5'd2;
    @(negedge clk);
    op_start = 0; rd_valid = 0;
    rd(5'd2);
    @(negedge clk);
    op_done = 1; rd_valid = 1; rd_sect = 5'd2;
    @(negedge clk);
    op_done = 0; rd_valid = 0;
    rd(5'd2);
    idle(4);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog [%s]: got timeout expected completion", scen);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule